// File: doc/BRIEF.md
# Debug Protocol Select Watcher

This block sits on the shared mode/data line of a two-protocol debug port. It samples the line on every rising edge of the debug clock and decides whether the port is driven by the JTAG engine or by the serial-wire engine. The chosen protocol appears on a mode output, and the surrounding logic uses that output to decide which engine owns the pin. The block comes out of power-on reset in JTAG mode. A JTAG host can therefore start work at once, with no selection step.

A host changes protocol in three steps. It first holds the line high for a long run of clocks, which puts both protocol engines into their reset condition. It then sends one of two 16-bit select words. The watcher counts the run of ones in a saturating counter and arms once the run is long enough. It then shifts in the 16 bits that follow the run and compares them with both select words. A match switches the mode and raises a one-cycle pulse, but only if the active engine reported its reset condition when the first pattern bit arrived. Each engine supplies its reset status as a single input. Whatever the result, the matcher disarms once the 16 bits have been compared, and a new run of ones is needed before the next word.

Top module: `dbg_proto_sel`

## Requirements
- R1: While `por_n` is low, and after it is released, `mode_swire_o` is 0 (JTAG) and `switch_pulse_o` is 0, without any select word having been sent.
- R2: A select word is recognised only if at least `ARM_RUN` (default 51) consecutive ones come before it. A zero seen before the run completes restarts the count. Further ones after the run completes keep the matcher armed. The first zero after the run is the first bit of the word.
- R3: The word 0111100111100111 (first bit on the wire written first, i.e. 16'h79E7 sent MSB first) sets `mode_swire_o` to 1. The change happens on the clock edge that samples the 16th bit.
- R4: The word 0011110011100111 (16'h3CE7 sent MSB first) sets `mode_swire_o` to 0. The change happens on the clock edge that samples the 16th bit.
- R5: A select word is accepted only if the active protocol's reset input was 1 on the clock edge that sampled the word's first bit. That input is `jtag_in_reset_i` when `mode_swire_o`=0 and `swire_in_reset_i` when it is 1. If the input was 0, neither the mode nor the pulse changes.
- R6: Every accepted word drives `switch_pulse_o` high for exactly one cycle, starting at the edge that samples the 16th bit. This includes a word that selects the mode already active, which leaves the mode unchanged. The mode never changes without this pulse.
- R7: After arming, any 16-bit word other than the two select words leaves the mode unchanged and raises no pulse.
- R8: The matcher disarms once 16 bits have been compared, whether they matched or not. A select word sent straight afterwards, with no new run of ones, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dbg | input | 1 | Debug clock; the line is sampled on its rising edge |
| por_n | input | 1 | Power-on reset, active low; asserts asynchronously and is released synchronously inside the block |
| line_in | input | 1 | Shared debug mode/data line |
| jtag_in_reset_i | input | 1 | 1 while the JTAG engine is in Test-Logic-Reset |
| swire_in_reset_i | input | 1 | 1 while the serial-wire engine is in line reset |
| mode_swire_o | output | 1 | Active protocol: 0 = JTAG, 1 = serial-wire |
| switch_pulse_o | output | 1 | One-cycle pulse for each accepted select word |

## Verification
The bench builds the block with its defaults: `ARM_RUN` = 51, a 16-bit word and the two standard select words. At these values a trial costs only about 75 clocks, so every arming boundary can be swept exactly, for runs of 0, 49, 50, 51, 52 and well beyond. In the same cycle budget the bench also runs:
- every single-bit corruption of both words;
- a batch of pseudo-random words;
- all four combinations of the two reset inputs in both modes.

Expected mode and pulse values come from a small rule set evaluated per trial. That rule set uses only the run length, the word sent and the reset inputs.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

  typedef enum logic {
    MODE_JTAG  = 1'b0,
    MODE_SWIRE = 1'b1
  } dsel_mode_e;

endpackage

// File: rtl/dsel_rst_sync.sv
module dsel_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/dsel_run_arm.sv
module dsel_run_arm #(
  parameter int ARM_RUN = 51
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic done_i,
  output logic armed_o
);

  localparam int CNT_W = $clog2(ARM_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ARM_RUN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ARM_RUN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en, armed_en;

  // next state
  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (armed_q) begin
      if (done_i) begin
        cnt_d   = '0;
        armed_d = 1'b0;
      end
    end else if (line_i) begin
      if (cnt_q != CNT_FULL) begin
        cnt_d = cnt_q + 1'b1;
      end
      if (cnt_q == CNT_LAST) begin
        armed_d = 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  assign cnt_en   = !armed_q || done_i;
  assign armed_en = cnt_en;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (armed_en) armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  // R2
  run_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R2
  arm_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(line_i));

endmodule

// File: rtl/dsel_shift_cmp.sv
module dsel_shift_cmp #(
  parameter int               PAT_W     = 16,
  parameter logic [PAT_W-1:0] PAT_TO_SW = 16'h79E7,
  parameter logic [PAT_W-1:0] PAT_TO_JT = 16'h3CE7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic armed_i,
  input  logic act_rst_i,
  output logic done_o,
  output logic hit_sw_o,
  output logic hit_jt_o
);

  localparam int BC_W = $clog2(PAT_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(PAT_W - 1);

  logic [PAT_W-2:0] sh_q, sh_d;
  logic [BC_W-1:0]  bcnt_q, bcnt_d;
  logic             qual_q, qual_d;
  logic             take, last, first;
  logic             sh_en, bcnt_en, qual_en;
  logic [PAT_W-1:0] word;

  // a bit is taken once armed; leading ones extend the run
  assign take  = armed_i && ((bcnt_q != '0) || !line_i);
  assign first = take && (bcnt_q == '0);
  assign last  = take && (bcnt_q == BC_LAST);
  assign word  = {sh_q, line_i};

  // next state
  always_comb begin
    sh_d   = {sh_q[PAT_W-3:0], line_i};
    bcnt_d = last ? '0 : bcnt_q + 1'b1;
    qual_d = act_rst_i;
  end

  assign sh_en   = take;
  assign bcnt_en = take;
  assign qual_en = first;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= '0;
      qual_q <= 1'b0;
    end else begin
      if (sh_en)   sh_q   <= sh_d;
      if (bcnt_en) bcnt_q <= bcnt_d;
      if (qual_en) qual_q <= qual_d;
    end
  end

  assign done_o   = last;
  assign hit_sw_o = last && qual_q && (word == PAT_TO_SW);
  assign hit_jt_o = last && qual_q && (word == PAT_TO_JT);

  // R8
  collect_while_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt_q != '0) |-> armed_i);

  // R7
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_sw_o && hit_jt_o));

endmodule

// File: rtl/dsel_mode_reg.sv
module dsel_mode_reg
  import dsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_sw_i,
  input  logic hit_jt_i,
  output logic mode_o,
  output logic pulse_o
);

  dsel_mode_e mode_q, mode_d;
  logic       pulse_q, pulse_d;
  logic       mode_en;

  // next state
  always_comb begin
    mode_d  = mode_q;
    if (hit_sw_i) begin
      mode_d = MODE_SWIRE;
    end else if (hit_jt_i) begin
      mode_d = MODE_JTAG;
    end
    pulse_d = hit_sw_i || hit_jt_i;
  end

  assign mode_en = hit_sw_i || hit_jt_i;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_JTAG;
      pulse_q <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      pulse_q <= pulse_d;
    end
  end

  assign mode_o  = mode_q;
  assign pulse_o = pulse_q;

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R6
  mode_moves_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> pulse_q);

endmodule

// File: rtl/dbg_proto_sel.sv
module dbg_proto_sel #(
  parameter int               ARM_RUN   = 51,
  parameter int               PAT_W     = 16,
  parameter logic [PAT_W-1:0] PAT_TO_SW = 16'h79E7,
  parameter logic [PAT_W-1:0] PAT_TO_JT = 16'h3CE7
) (
  input  logic clk_dbg,
  input  logic por_n,
  input  logic line_in,
  input  logic jtag_in_reset_i,
  input  logic swire_in_reset_i,
  output logic mode_swire_o,
  output logic switch_pulse_o
);

  logic rst_n;
  logic armed, done, hit_sw, hit_jt;
  logic mode, act_rst;

  dsel_rst_sync u_rst (
    .clk    (clk_dbg),
    .arst_n (por_n),
    .rst_n  (rst_n)
  );

  dsel_run_arm #(.ARM_RUN(ARM_RUN)) u_arm (
    .clk     (clk_dbg),
    .rst_n   (rst_n),
    .line_i  (line_in),
    .done_i  (done),
    .armed_o (armed)
  );

  assign act_rst = mode ? swire_in_reset_i : jtag_in_reset_i;

  dsel_shift_cmp #(
    .PAT_W     (PAT_W),
    .PAT_TO_SW (PAT_TO_SW),
    .PAT_TO_JT (PAT_TO_JT)
  ) u_cmp (
    .clk       (clk_dbg),
    .rst_n     (rst_n),
    .line_i    (line_in),
    .armed_i   (armed),
    .act_rst_i (act_rst),
    .done_o    (done),
    .hit_sw_o  (hit_sw),
    .hit_jt_o  (hit_jt)
  );

  dsel_mode_reg u_mode (
    .clk      (clk_dbg),
    .rst_n    (rst_n),
    .hit_sw_i (hit_sw),
    .hit_jt_i (hit_jt),
    .mode_o   (mode),
    .pulse_o  (switch_pulse_o)
  );

  assign mode_swire_o = mode;

  // R8
  disarm_after_word_chk: assert property (@(posedge clk_dbg) disable iff (!rst_n)
    done |=> !armed);

endmodule

// File: tb/dbg_proto_sel_test.sv
module dbg_proto_sel_test;

  localparam int          ARM_RUN = 51;
  localparam logic [15:0] P_SW    = 16'h79E7;
  localparam logic [15:0] P_JT    = 16'h3CE7;

  logic clk = 1'b0;
  logic por_n, line, jt_rst, sw_rst;
  logic mode_sw, pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 0;
  bit exp_mode  = 0;

  always #10 clk = ~clk;

  dbg_proto_sel uut (
    .clk_dbg          (clk),
    .por_n            (por_n),
    .line_in          (line),
    .jtag_in_reset_i  (jt_rst),
    .swire_in_reset_i (sw_rst),
    .mode_swire_o     (mode_sw),
    .switch_pulse_o   (pulse)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    line = b;
  endtask

  // zero, pre ones, zero, n ones, 16-bit word MSB first
  task automatic trial(input int pre, input int n, input logic [15:0] w,
                       input logic jt, input logic sw, input string req);
    bit armed, gate, acc, exp_pulse;
    jt_rst = jt;
    sw_rst = sw;
    send_bit(1'b0);
    repeat (pre) send_bit(1'b1);
    send_bit(1'b0);
    repeat (n) send_bit(1'b1);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    armed = (n >= ARM_RUN);
    gate  = exp_mode ? sw : jt;
    acc   = armed && gate && ((w == P_SW) || (w == P_JT));
    exp_pulse = acc;
    if (acc) exp_mode = (w == P_SW);
    @(negedge clk);
    check(mode_sw, exp_mode, req, "mode after word");
    check(pulse, exp_pulse, req, "pulse after word");
    @(negedge clk);
    check(pulse, 1'b0, "R6", "pulse one cycle later");
  endtask

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    por_n = 1'b0; line = 1'b1; jt_rst = 1'b1; sw_rst = 1'b1;
    repeat (4) @(negedge clk);
    check(mode_sw, 1'b0, "R1", "mode in reset");
    check(pulse, 1'b0, "R1", "pulse in reset");
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mode_sw, 1'b0, "R1", "mode after release");
    check(pulse, 1'b0, "R1", "pulse after release");

    // R2 run-length boundaries, alternating words (R3, R4)
    trial(0, 50, P_SW, 1, 1, "R2");
    trial(0, 49, P_SW, 1, 1, "R2");
    trial(0, 51, P_SW, 1, 1, "R3");
    trial(0, 51, P_JT, 1, 1, "R4");
    trial(0, 52, P_SW, 1, 1, "R3");
    trial(0, 100, P_JT, 1, 1, "R2");
    trial(0, 0, P_SW, 1, 1, "R2");
    trial(0, 10, P_SW, 1, 1, "R2");
    trial(50, 40, P_SW, 1, 1, "R2");
    trial(0, 60, P_SW, 1, 1, "R3");
    // same-mode select still pulses (R6)
    trial(0, 55, P_SW, 1, 1, "R6");
    trial(0, 55, P_JT, 1, 1, "R4");
    trial(0, 55, P_JT, 1, 1, "R6");
    // R8 word straight after a completed word
    trial(0, 0, P_SW, 1, 1, "R8");

    // R5 reset qualification, both modes, all input combinations
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        trial(0, 55, (m == 0) ? P_JT : P_SW, 1, 1, "R5");
        trial(0, 55, (m == 0) ? P_SW : P_JT, c[0], c[1], "R5");
      end
    end

    // R7 single-bit corruptions (leading bit kept at 0)
    for (int b = 0; b < 15; b++) begin
      trial(0, 51, P_SW ^ (16'h1 << b), 1, 1, "R7");
      trial(0, 51, P_JT ^ (16'h1 << b), 1, 1, "R7");
    end

    // R7 pseudo-random words with leading 0
    lf = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      trial(0, 51, {1'b0, lf[14:0]}, 1, 1, "R7");
    end

    // R1 power-on reset from serial-wire mode
    trial(0, 51, P_SW, 1, 1, "R3");
    @(negedge clk);
    por_n = 1'b0;
    #1;
    check(mode_sw, 1'b0, "R1", "mode on reset assertion");
    exp_mode = 0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mode_sw, 1'b0, "R1", "mode after second release");
    trial(0, 51, P_SW, 1, 1, "R3");

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule